// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the control core of a four-channel data-acquisition front end that samples all of its channels at the same instant and then digitises them one after another with a single shared converter. Software programs it by writing a 4-bit control word over a small parallel port, using an active-low select and an active-low write strobe. The word chooses one of two input banks, how many channels (one to four) are converted per sample, and whether the block is powered down.

A rising edge on the start input freezes all four sample holders at once, copying in the selected bank's four inputs. The sequencer then steps through channels 1, 2, 3 and 4 in that order, stopping after the programmed count. Each channel takes a fixed number of clock cycles, and each result goes into its slot of a four-entry result store. When the last channel finishes, the holders return to tracking and an active-low interrupt falls. The converter is modelled digitally: the result of a channel is the held sample, and it appears after the per-channel latency.

Top module: `convSequencer`

## Requirements
- R1: After reset, intN is 1, holdOut is 0, every result slot reads zero, and the mode is bank A with one channel, not powered down.
- R2: The control word is taken from ctrlIn while csN and wrN are both low. It is applied when that condition ends, whether csN or wrN rises first. A wrN pulse while csN is high changes nothing. Encoding: bit 3 = 1 means power-down (other bits don't care), bit 2 selects the bank (0 = A, 1 = B), and bits 1:0 hold the channel count minus one.
- R3: The start input is sampled on the clock. Its rising edge is accepted on the first clock at which it reads high, and at that clock all four inputs of the selected bank are captured together. holdOut is 1 from that clock until the sequence ends, and changes on the bank inputs during the sequence do not alter any result.
- R4: Channels are converted in order starting at channel 1, each taking LAT cycles. The result for channel k (k = 1..N) is in its slot LAT*k cycles after the accepting clock, and later slots still hold their old value at that point.
- R5: intN falls, and holdOut falls, exactly N*LAT cycles after the accepting clock, where N is the programmed channel count. Neither falls earlier.
- R6: Start edges that arrive while a sequence is running are ignored. The sequence neither restarts nor changes its timing or results.
- R7: While powered down, start edges are ignored: holdOut stays 0, and intN and all result slots keep their values. A later word with bit 3 = 0 wakes the block in the mode that word gives.
- R8: A written mode applies to every later sequence until another word is written.
- R9: intN returns to 1 on the clock that accepts a new sequence.
- R10: Result slots beyond the programmed channel count keep the values they held before the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low port select |
| wrN | input | 1 | Active-low write strobe |
| ctrlIn | input | 4 | Control word |
| startIn | input | 1 | Conversion start, rising edge active |
| bankAIn | input | 4*W | Bank A inputs, channel k at bits [(k-1)*W +: W] |
| bankBIn | input | 4*W | Bank B inputs, same layout |
| intN | output | 1 | Active-low end-of-sequence interrupt |
| holdOut | output | 1 | 1 while the sample holders are frozen |
| resultOut | output | 4*W | Result store, channel k at bits [(k-1)*W +: W] |

## Verification
On every cycle, the assertions check these rules: the interrupt is never low during a running sequence, and the holders release only together with the interrupt falling. A start edge in mid-sequence must only advance the cycle counter, power-down must keep the sequencer idle, the held samples move only on a capture, and the result store moves only on a channel write. Only the bench scenarios can show the following: the exact cycle at which each slot and the interrupt change, the decoding of every bank and count, and mode persistence across several starts. They also cover the two orders in which the select and write strobes can end, and waking from power-down with a new mode.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int CHANS = 4;
  localparam int IDXW  = $clog2(CHANS);

  // strobes from control to datapath
  typedef struct packed {
    logic            capture;  // freeze all holders this cycle
    logic            bankSel;  // 0 = bank A, 1 = bank B
    logic            write;    // commit one channel result
    logic [IDXW-1:0] idx;      // channel being committed
  } seqStrobeT;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int LAT = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       wrN,
  input  logic [3:0] ctrlIn,
  input  logic       startIn,
  output seqStrobeT  strobe,
  output logic       intN,
  output logic       busy
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(LAT - 1);

  logic            selNow, selPrev;
  logic [3:0]      wordHold;
  logic            cfgPd, cfgBankB;
  logic [IDXW-1:0] cfgLast;
  logic            startPrev, startRise, accept;
  logic [IDXW-1:0] runLast, chanIdx;
  logic [CW-1:0]   cnt;
  logic            cntEnd;

  assign selNow    = !csN && !wrN;
  assign startRise = startIn && !startPrev;
  assign accept    = startRise && !busy && !cfgPd;
  assign cntEnd    = (cnt == CNT_END);

  // control word port: take data while selected, apply when selection ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev  <= 1'b0;
      wordHold <= 4'b0000;
      cfgPd    <= 1'b0;
      cfgBankB <= 1'b0;
      cfgLast  <= '0;
    end else begin
      selPrev <= selNow;
      if (selNow) wordHold <= ctrlIn;
      if (selPrev && !selNow) begin
        cfgPd    <= wordHold[3];
        cfgBankB <= wordHold[2];
        cfgLast  <= wordHold[IDXW-1:0];
      end
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPrev <= 1'b0;
      busy      <= 1'b0;
      intN      <= 1'b1;
      runLast   <= '0;
      chanIdx   <= '0;
      cnt       <= '0;
    end else begin
      startPrev <= startIn;
      if (accept) begin
        busy    <= 1'b1;
        intN    <= 1'b1;
        runLast <= cfgLast;
        chanIdx <= '0;
        cnt     <= '0;
      end else if (busy) begin
        if (cntEnd) begin
          cnt <= '0;
          if (chanIdx == runLast) begin
            busy <= 1'b0;
            intN <= 1'b0;
          end else begin
            chanIdx <= chanIdx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.capture = accept;
    strobe.bankSel = cfgBankB;
    strobe.write   = busy && cntEnd;
    strobe.idx     = chanIdx;
  end

  // R5: interrupt low only while idle
  p_int_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> !busy);

  // R5: holders release together with the interrupt falling
  p_hold_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !intN);

  // R6: a start edge in mid-sequence only advances the counter
  p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startRise && !cntEnd) |=> (busy && cnt == $past(cnt) + 1'b1));

  // R7: powered down and idle stays idle
  p_pd_blocks_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPd && !busy) |=> !busy);
endmodule

// File: rtl/seqData.sv
module seqData
  import seqPkg::*;
#(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobeT            strobe,
  input  logic [CHANS*W-1:0]   bankAIn,
  input  logic [CHANS*W-1:0]   bankBIn,
  output logic [CHANS*W-1:0]   resultOut
);
  logic [CHANS-1:0][W-1:0] holdReg;
  logic [CHANS-1:0][W-1:0] store;

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdReg[ch] <= '0;
        store[ch]   <= '0;
      end else begin
        if (strobe.capture)
          holdReg[ch] <= strobe.bankSel ? bankBIn[ch*W +: W] : bankAIn[ch*W +: W];
        if (strobe.write && strobe.idx == IDXW'(ch))
          store[ch] <= holdReg[ch];
      end
    end
    assign resultOut[ch*W +: W] = store[ch];
  end

  // R3: held samples move only on a capture
  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(holdReg));

  // R10: result store moves only on a channel write
  p_store_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.write |=> $stable(store));
endmodule

// File: rtl/convSequencer.sv
module convSequencer
  import seqPkg::*;
#(
  parameter int W   = 12,
  parameter int LAT = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               wrN,
  input  logic [3:0]         ctrlIn,
  input  logic               startIn,
  input  logic [4*W-1:0]     bankAIn,
  input  logic [4*W-1:0]     bankBIn,
  output logic               intN,
  output logic               holdOut,
  output logic [4*W-1:0]     resultOut
);
  seqStrobeT strobe;
  logic      busy;

  seqCtrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .ctrlIn(ctrlIn),
    .startIn(startIn), .strobe(strobe), .intN(intN), .busy(busy)
  );

  seqData #(.W(W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bankAIn(bankAIn), .bankBIn(bankBIn), .resultOut(resultOut)
  );

  assign holdOut = busy;
endmodule

// File: tb/sim_convSequencer.sv
module sim_convSequencer;
  localparam int W   = 12;
  localparam int LAT = 8;

  // {control word, sample base}
  localparam logic [15:0] VEC [6] = '{16'h0_123, 16'h3_456, 16'h5_789,
                                      16'h6_A0C, 16'h1_2F1, 16'h7_0E5};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rstN, csN, wrN, startIn;
  logic [3:0]     ctrlIn;
  logic [4*W-1:0] bankAIn, bankBIn;
  logic           intN, holdOut;
  logic [4*W-1:0] resultOut;

  int nChecks = 0;
  int nFail   = 0;
  logic [W-1:0] expStore [4];

  convSequencer #(.W(W), .LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .ctrlIn(ctrlIn),
    .startIn(startIn), .bankAIn(bankAIn), .bankBIn(bankBIn),
    .intN(intN), .holdOut(holdOut), .resultOut(resultOut)
  );

  function automatic logic [W-1:0] smp(input bit bankB, input logic [W-1:0] base, input int ch);
    logic [W-1:0] v;
    v = base + W'(ch) * 12'h111;
    return bankB ? ~v : v;
  endfunction

  function automatic logic [4*W-1:0] expFlat();
    logic [4*W-1:0] f;
    for (int i = 0; i < 4; i++) f[i*W +: W] = expStore[i];
    return f;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic putSamples(input logic [W-1:0] base);
    for (int ch = 0; ch < 4; ch++) begin
      bankAIn[ch*W +: W] = smp(1'b0, base, ch);
      bankBIn[ch*W +: W] = smp(1'b1, base, ch);
    end
  endtask

  task automatic writeWord(input logic [3:0] w);
    @(negedge clk); csN = 1'b0; wrN = 1'b0; ctrlIn = w;
    @(negedge clk); wrN = 1'b1; ctrlIn = 4'h0;
    @(negedge clk); csN = 1'b1;
    @(negedge clk);
  endtask

  // one full sequence with timing and result checks
  task automatic runSeq(input int n, input bit bankB, input logic [W-1:0] base,
                        input bit disturb, input string tag);
    putSamples(base);
    @(negedge clk); startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    // R3 R9: accepted on the first clock with start high
    chk(intN == 1'b1 && holdOut == 1'b1, {tag, " R3 R9 accept"}, {intN, holdOut}, 2'b11);
    for (int k = 1; k < n * LAT; k++) begin
      @(negedge clk);
      if (disturb && k == 3) begin
        putSamples(base + 12'h0AB);   // R3: held values must not follow
        startIn = 1'b1;               // R6: mid-sequence start edge
      end
      if (disturb && k == 5) startIn = 1'b0;
      if (k == LAT) begin
        // R4: channel 1 written, channel 2 not yet
        chk(resultOut[0 +: W] == smp(bankB, base, 0) && resultOut[W +: W] == expStore[1],
            {tag, " R4 order"}, resultOut[2*W-1:0], {expStore[1], smp(bankB, base, 0)});
      end
    end
    // R5: not early
    chk(intN == 1'b1 && holdOut == 1'b1, {tag, " R5 early"}, {intN, holdOut}, 2'b11);
    @(negedge clk);
    chk(intN == 1'b0 && holdOut == 1'b0, {tag, " R5 end"}, {intN, holdOut}, 2'b00);
    for (int i = 0; i < n; i++) expStore[i] = smp(bankB, base, i);
    // R4 R10 R6: results, untouched slots kept
    chk(resultOut == expFlat(), {tag, " R4 R10 results"}, resultOut, expFlat());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; wrN = 1'b1; ctrlIn = 4'h0; startIn = 1'b0;
    bankAIn = '0; bankBIn = '0;
    for (int i = 0; i < 4; i++) expStore[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(intN == 1'b1 && holdOut == 1'b0, "R1 outputs", {intN, holdOut}, 2'b10);
    chk(resultOut == '0, "R1 store", resultOut, '0);
    runSeq(1, 1'b0, 12'h3C1, 1'b0, "R1 default mode");

    // R2: write strobe while not selected is ignored
    @(negedge clk); csN = 1'b1; wrN = 1'b0; ctrlIn = 4'b0111;
    @(negedge clk); wrN = 1'b1; ctrlIn = 4'h0;
    @(negedge clk);
    runSeq(1, 1'b0, 12'h2A2, 1'b0, "R2 unselected write");

    // vector table; each word used for two sequences (R8)
    for (int v = 0; v < 6; v++) begin
      logic [3:0]   w;
      logic [W-1:0] b;
      w = VEC[v][15:12];
      b = VEC[v][W-1:0];
      writeWord(w);
      runSeq(int'(w[1:0]) + 1, w[2], b, v[0], "R2 table");
      runSeq(int'(w[1:0]) + 1, w[2], b ^ 12'h5A5, 1'b0, "R8 persist");
    end

    // R2: select ends before write
    @(negedge clk); csN = 1'b0; wrN = 1'b0; ctrlIn = 4'b0011;
    @(negedge clk); csN = 1'b1; ctrlIn = 4'h0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk);
    runSeq(4, 1'b0, 12'h0F0, 1'b1, "R2 select first");

    // R7: power-down ignores start
    writeWord(4'b1010);
    putSamples(12'h777);
    @(negedge clk); startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    chk(holdOut == 1'b0, "R7 no hold", holdOut, 1'b0);
    repeat (4 * LAT + 4) @(negedge clk);
    chk(intN == 1'b0 && holdOut == 1'b0, "R7 no interrupt", {intN, holdOut}, 2'b00);
    chk(resultOut == expFlat(), "R7 store kept", resultOut, expFlat());

    // R7: wake with bank B, two channels
    writeWord(4'b0101);
    runSeq(2, 1'b1, 12'h4D4, 1'b0, "R7 wake");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule